// File: doc/BRIEF.md
# Three-Lane 7:1 Pixel Serializer

This block turns a 21-bit parallel pixel word into three serial lanes. A new word arrives once per pixel clock. Each lane sends seven bits of it in every pixel period. A forwarded clock runs at the pixel rate alongside the data. It is high for four bit slots and low for three, so a receiver can find where each frame starts from the rising edge of that clock.

The pixel word is captured on the falling edge of the pixel clock. It then passes into the bit-clock domain through a holding register. Three parallel-load shift registers, driven by a bit clock at seven times the pixel rate, put the word on the lanes. An active-low shutdown input clears every register at once, parks all outputs at zero and restarts a settle counter. A link-valid flag reports when the bit clock has run long enough for the output to be trusted.

Top module: `video_lane_serializer`

## Requirements
- R1: Lane k (k = 0, 1, 2) carries only word bits 7k to 7k+6. Every pixel word appears on the lanes exactly once, in the order the words were presented.
- R2: Within a frame, lane k sends bit 7k+6 in the first slot and then lower indices in turn, ending with bit 7k in the seventh slot.
- R3: The word is sampled on the falling edge of `pix_clk`. A value present only between a falling edge and the next rising edge never reaches the lanes.
- R4: `fwd_clk` repeats every 7 bit-clock cycles. In each repetition it is high for 4 consecutive cycles and low for 3.
- R5: Slot 0 of every frame begins in the same bit-clock cycle in which `fwd_clk` rises. The parallel load into the shift registers happens at that same edge.
- R6: While `shutdown_n` is low, `ser_lane`, `fwd_clk` and `link_valid` are all zero. This holds asynchronously and for any input word, and all internal registers are cleared.
- R7: After `shutdown_n` rises, `link_valid` rises at the first frame boundary that comes after at least SETTLE_CYCLES bit-clock edges. For the default of 24, that is the 29th bit-clock edge after release, which is also the edge where `fwd_clk` rises.
- R8: Once `link_valid` is high, it stays high until `shutdown_n` goes low.
- R9: The holding register does not change at the edge that loads the shift registers, so every load takes a whole word.
- R10: After release, the first bit-clock edge starts a frame: `fwd_clk` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock; the word is captured on its falling edge |
| shutdown_n | input | 1 | Active-low shutdown and asynchronous clear |
| pix_word | input | 21 | Parallel pixel word |
| ser_lane | output | 3 | Serial data, one bit per lane, MSB of each lane slice first |
| fwd_clk | output | 1 | Forwarded frame clock, 4 slots high and 3 slots low |
| link_valid | output | 1 | High once the settle count has elapsed, aligned to a frame start |

## Verification
The hardest thing to show from the ports is that the pixel-domain capture really samples on the falling edge and nowhere else. The load must also never pick up a word that is only half transferred. To probe this, the stimulus replaces every pixel word with its complement just after each falling edge and holds the complement until the next rising edge. Any early or late sampling would then surface a complemented word in the stream. The bench rebuilds words from the lanes using only the rising edge of the forwarded clock. It then matches the recovered sequence against the sent sequence at the best frame offset. Several patterns are used: a counting pattern, a walking one, a walking zero, per-lane tags and a pseudo-random pattern. Together they expose swapped lanes, reversed bit order, and dropped or repeated frames.

// File: rtl/vser_pkg.sv
package vser_pkg;

    // default geometry of the link
    localparam int DEF_LANES      = 3;
    localparam int DEF_LANE_BITS  = 7;
    localparam int DEF_HIGH_SLOTS = 4;
    localparam int DEF_SETTLE     = 24;

    // counter width that holds values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/vser_capture.sv
module vser_capture #(
    parameter int WORD_W = 21
) (
    input  logic              pix_clk,
    input  logic              bit_clk,
    input  logic              clr_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_stb,
    output logic [WORD_W-1:0] hold_o
);

    logic [WORD_W-1:0] cap_d, cap_q;
    logic [WORD_W-1:0] hold_d, hold_q;

    always_comb begin
        cap_d  = word_i;
        // freeze the holding copy while the shift registers take it
        hold_d = load_stb ? hold_q : cap_q;
    end

    // pixel-domain capture on the falling edge
    always_ff @(negedge pix_clk or negedge clr_n) begin
        if (!clr_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // bit-domain holding register
    always_ff @(posedge bit_clk or negedge clr_n) begin
        if (!clr_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/vser_ctrl.sv
module vser_ctrl #(
    parameter int LANE_BITS     = 7,
    parameter int HIGH_SLOTS    = 4,
    parameter int SETTLE_CYCLES = 24
) (
    input  logic bit_clk,
    input  logic clr_n,
    output logic load_stb,
    output logic fclk_o,
    output logic valid_o
);
    import vser_pkg::*;

    localparam int SLOT_W = cnt_width(LANE_BITS - 1);
    localparam int CNT_W  = cnt_width(SETTLE_CYCLES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANE_BITS - 1);
    localparam logic [SLOT_W-1:0] HIGH_LIM  = SLOT_W'(HIGH_SLOTS);
    localparam logic [CNT_W-1:0]  SETTLE_LIM = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              fclk;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{slot: LAST_SLOT, fclk: 1'b0, cnt: '0, valid: 1'b0};

    ctrl_t st_d, st_q;
    logic [SLOT_W-1:0] nxt_slot;
    logic              load_now;
    logic              settled;

    always_comb begin
        load_now = (st_q.slot == LAST_SLOT);
        settled  = (st_q.cnt == SETTLE_LIM);
        nxt_slot = load_now ? '0 : st_q.slot + 1'b1;

        st_d       = st_q;
        st_d.slot  = nxt_slot;
        st_d.fclk  = (nxt_slot < HIGH_LIM);
        st_d.cnt   = settled ? st_q.cnt : st_q.cnt + 1'b1;
        // valid only rises on a frame boundary
        st_d.valid = st_q.valid | (load_now & settled);
    end

    always_ff @(posedge bit_clk or negedge clr_n) begin
        if (!clr_n) st_q <= CTRL_RST;
        else        st_q <= st_d;
    end

    assign load_stb = load_now;
    assign fclk_o   = st_q.fclk;
    assign valid_o  = st_q.valid;

endmodule

// File: rtl/vser_lane.sv
module vser_lane #(
    parameter int LANE_BITS = 7
) (
    input  logic                 bit_clk,
    input  logic                 clr_n,
    input  logic                 load_stb,
    input  logic [LANE_BITS-1:0] par_i,
    output logic                 ser_o
);

    logic [LANE_BITS-1:0] sreg_d, sreg_q;

    always_comb begin
        if (load_stb) sreg_d = par_i;
        else          sreg_d = {sreg_q[LANE_BITS-2:0], 1'b0};
    end

    always_ff @(posedge bit_clk or negedge clr_n) begin
        if (!clr_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    // most significant bit leaves first
    assign ser_o = sreg_q[LANE_BITS-1];

endmodule

// File: rtl/video_lane_serializer.sv
module video_lane_serializer #(
    parameter int LANES          = vser_pkg::DEF_LANES,
    parameter int LANE_BITS      = vser_pkg::DEF_LANE_BITS,
    parameter int CLK_HIGH_SLOTS = vser_pkg::DEF_HIGH_SLOTS,
    parameter int SETTLE_CYCLES  = vser_pkg::DEF_SETTLE,
    localparam int WORD_W        = LANES * LANE_BITS
) (
    input  logic              bit_clk,
    input  logic              pix_clk,
    input  logic              shutdown_n,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  ser_lane,
    output logic              fwd_clk,
    output logic              link_valid
);

    logic              load_stb;
    logic [WORD_W-1:0] hold_word;

    vser_capture #(.WORD_W(WORD_W)) u_capture (
        .pix_clk  (pix_clk),
        .bit_clk  (bit_clk),
        .clr_n    (shutdown_n),
        .word_i   (pix_word),
        .load_stb (load_stb),
        .hold_o   (hold_word)
    );

    vser_ctrl #(
        .LANE_BITS     (LANE_BITS),
        .HIGH_SLOTS    (CLK_HIGH_SLOTS),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_ctrl (
        .bit_clk  (bit_clk),
        .clr_n    (shutdown_n),
        .load_stb (load_stb),
        .fclk_o   (fwd_clk),
        .valid_o  (link_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vser_lane #(.LANE_BITS(LANE_BITS)) u_lane (
            .bit_clk  (bit_clk),
            .clr_n    (shutdown_n),
            .load_stb (load_stb),
            .par_i    (hold_word[g*LANE_BITS +: LANE_BITS]),
            .ser_o    (ser_lane[g])
        );
    end

endmodule

// File: rtl/vser_chk.sv
module vser_chk #(
    parameter int LANES      = 3,
    parameter int LANE_BITS  = 7,
    parameter int HIGH_SLOTS = 4,
    parameter int WORD_W     = 21
) (
    input logic              bit_clk,
    input logic              shutdown_n,
    input logic [LANES-1:0]  ser_lane,
    input logic              fwd_clk,
    input logic              link_valid,
    input logic              load_stb,
    input logic [WORD_W-1:0] hold_word
);

    logic       prev_q;
    logic [3:0] run_q;
    logic       fell_seen_q;

    always_ff @(posedge bit_clk or negedge shutdown_n) begin
        if (!shutdown_n) begin
            prev_q      <= 1'b0;
            run_q       <= '0;
            fell_seen_q <= 1'b0;
        end else begin
            prev_q <= fwd_clk;
            if (fwd_clk != prev_q)  run_q <= 4'd1;
            else if (run_q != 4'hF) run_q <= run_q + 4'd1;
            if (prev_q && !fwd_clk) fell_seen_q <= 1'b1;
        end
    end

    // R6
    always @(negedge bit_clk) begin
        if (!shutdown_n) begin
            shutdown_quiet_chk: assert (ser_lane == '0 && !fwd_clk && !link_valid)
                else $error("outputs active during shutdown");
        end
    end

    // R4
    fclk_high_run_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        (prev_q && !fwd_clk) |-> (run_q == 4'(HIGH_SLOTS)));

    // R4
    fclk_low_run_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        (fwd_clk && !prev_q && fell_seen_q) |-> (run_q == 4'(LANE_BITS - HIGH_SLOTS)));

    // R5
    load_on_rise_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        load_stb |=> $rose(fwd_clk));

    // R9
    hold_frozen_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        load_stb |=> $stable(hold_word));

    // R7
    valid_at_frame_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        $rose(link_valid) |-> $rose(fwd_clk));

    // R8
    valid_sticky_chk: assert property (@(posedge bit_clk) disable iff (!shutdown_n)
        link_valid |=> link_valid);

endmodule

bind video_lane_serializer vser_chk #(
    .LANES      (LANES),
    .LANE_BITS  (LANE_BITS),
    .HIGH_SLOTS (CLK_HIGH_SLOTS),
    .WORD_W     (WORD_W)
) u_vser_chk (
    .bit_clk    (bit_clk),
    .shutdown_n (shutdown_n),
    .ser_lane   (ser_lane),
    .fwd_clk    (fwd_clk),
    .link_valid (link_valid),
    .load_stb   (load_stb),
    .hold_word  (hold_word)
);

// File: tb/video_lane_serializer_bench.sv
module video_lane_serializer_bench;

    localparam int LANES  = 3;
    localparam int LB     = 7;
    localparam int WW     = LANES * LB;
    localparam int SETTLE = 24;

    logic          bit_clk    = 1'b0;
    logic          pix_clk    = 1'b0;
    logic          shutdown_n = 1'b0;
    logic [WW-1:0] pix_word   = '0;
    logic [LANES-1:0] ser_lane;
    logic          fwd_clk;
    logic          link_valid;

    int total = 0;
    int bad   = 0;

    always #4 bit_clk = ~bit_clk;
    initial begin
        #2;
        forever #28 pix_clk = ~pix_clk;
    end

    video_lane_serializer #(.SETTLE_CYCLES(SETTLE)) u_video_lane_serializer (
        .bit_clk    (bit_clk),
        .pix_clk    (pix_clk),
        .shutdown_n (shutdown_n),
        .pix_word   (pix_word),
        .ser_lane   (ser_lane),
        .fwd_clk    (fwd_clk),
        .link_valid (link_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // receiver model: frames found from the forwarded clock alone
    logic [WW-1:0] rec [0:79];
    logic [WW-1:0] sent [0:63];
    int            rec_n  = 0;
    bit            rec_on = 0;
    bit            d_prev = 0;
    bit            d_have = 0;
    int            d_slot = 0;
    logic [WW-1:0] d_acc  = '0;

    always @(negedge bit_clk) begin
        if (!shutdown_n) begin
            d_prev = 0;
            d_have = 0;
            d_slot = 0;
        end else begin
            if (fwd_clk && !d_prev) begin
                d_slot = 0;
                d_have = 1;
            end else if (d_slot < LB) begin
                d_slot++;
            end
            d_prev = fwd_clk;
            if (d_have && d_slot < LB) begin
                for (int l = 0; l < LANES; l++) d_acc[l*LB + LB - 1 - d_slot] = ser_lane[l];
                if (d_slot == LB - 1 && rec_on && link_valid && rec_n < 80) begin
                    rec[rec_n] = d_acc;
                    rec_n++;
                end
            end
        end
    end

    function automatic logic [WW-1:0] gen(input int mode, input int i);
        logic [WW-1:0] s;
        case (mode)
            0: return WW'(i * 32'h0004_A3B5 + 32'h0001_2345);
            1: return WW'(1) << (i % WW);
            2: return ~(WW'(1) << (i % WW));
            3: return {7'(i * 5 + 2), 7'(i * 3 + 1), 7'(i)};
            default: begin
                s = 21'h1ACE1;
                for (int k = 0; k <= i; k++) s = {s[WW-2:0], s[WW-1] ^ s[WW-3]};
                return s;
            end
        endcase
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge bit_clk);
        chk(ser_lane == '0, "R6", "lanes in shutdown", 32'(ser_lane), 0);
        chk(fwd_clk == 1'b0, "R6", "fwd_clk in shutdown", 32'(fwd_clk), 0);
        chk(link_valid == 1'b0, "R6", "valid in shutdown", 32'(link_valid), 0);
    endtask

    task automatic t_release;
        int  cnt;
        int  exp_k;
        bit  prev_f;
        exp_k = SETTLE + 1;
        while (exp_k % LB != 1) exp_k++;
        @(negedge bit_clk);
        shutdown_n = 1'b1;
        @(negedge bit_clk);
        cnt = 1;
        chk(fwd_clk == 1'b1, "R10", "fwd_clk after first edge", 32'(fwd_clk), 1);
        chk(link_valid == 1'b0, "R7", "valid before settle", 32'(link_valid), 0);
        prev_f = fwd_clk;
        while (!link_valid && cnt < 500) begin
            prev_f = fwd_clk;
            @(negedge bit_clk);
            cnt++;
        end
        chk(cnt == exp_k, "R7", "edges until valid", 32'(cnt), 32'(exp_k));
        chk(fwd_clk && !prev_f, "R7", "valid on fwd_clk rise", {30'd0, prev_f, fwd_clk}, 32'b01);
    endtask

    task automatic t_clock_shape;
        bit prev_f;
        prev_f = fwd_clk;
        @(negedge bit_clk);
        while (!(fwd_clk && !prev_f)) begin
            prev_f = fwd_clk;
            @(negedge bit_clk);
        end
        for (int s = 0; s < 2 * LB; s++) begin
            chk(fwd_clk == ((s % LB) < 4), "R4", $sformatf("fwd_clk slot %0d", s),
                32'(fwd_clk), 32'((s % LB) < 4));
            @(negedge bit_clk);
        end
    endtask

    task automatic t_stream(input int mode, input int n, input string name);
        logic [WW-1:0] w;
        int best_d;
        int best_miss;
        int miss;
        logic [WW-1:0] act;
        rec_n  = 0;
        rec_on = 1;
        for (int i = 0; i < n; i++) begin
            w = gen(mode, i);
            sent[i] = w;
            @(posedge pix_clk);
            #1 pix_word = w;
            @(negedge pix_clk);
            #1 pix_word = ~w;   // only present outside the sampling edge
        end
        @(posedge pix_clk);
        #1 pix_word = sent[n-1];
        repeat (5) @(posedge pix_clk);
        rec_on = 0;
        best_d = 0;
        best_miss = n + 1;
        for (int d = 0; d < LB; d++) begin
            miss = 0;
            for (int i = 0; i < n; i++)
                if (i + d >= rec_n || rec[i + d] != sent[i]) miss++;
            if (miss < best_miss) begin
                best_miss = miss;
                best_d = d;
            end
        end
        for (int i = 0; i < n; i++) begin
            act = (i + best_d < rec_n) ? rec[i + best_d] : '0;
            // R1 lane slices, R2 bit order, R3 falling-edge capture, R5 frame start, R9 whole-word load
            chk(act == sent[i], "R1 R2 R3 R5 R9", $sformatf("%s word %0d", name, i),
                32'(act), 32'(sent[i]));
        end
    endtask

    task automatic t_valid_hold;
        bit dropped;
        dropped = 0;
        repeat (100) begin
            @(negedge bit_clk);
            if (!link_valid) dropped = 1;
        end
        chk(!dropped, "R8", "valid stays high", 32'(dropped), 0);
    endtask

    task automatic t_shutdown_mid;
        @(posedge pix_clk);
        #1 pix_word = '1;
        repeat (3) @(posedge pix_clk);
        @(negedge bit_clk);
        chk(ser_lane == 3'b111, "R1", "all-ones word on every lane", 32'(ser_lane), 32'h7);
        #2 shutdown_n = 1'b0;
        #1;
        chk(ser_lane == '0, "R6", "lanes clear at once", 32'(ser_lane), 0);
        chk(fwd_clk == 1'b0, "R6", "fwd_clk clear at once", 32'(fwd_clk), 0);
        chk(link_valid == 1'b0, "R6", "valid clear at once", 32'(link_valid), 0);
        repeat (20) @(negedge bit_clk);
        chk(ser_lane == '0 && !fwd_clk && !link_valid, "R6", "held quiet with input ones",
            {29'd0, ser_lane}, 0);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        t_reset();
        t_release();
        t_clock_shape();
        t_stream(0, 40, "counting");
        t_stream(1, 21, "walking one");
        t_stream(2, 21, "walking zero");
        t_stream(3, 30, "lane tags");
        t_stream(4, 40, "pseudo random");
        t_valid_hold();
        t_shutdown_mid();
        t_release();
        t_stream(3, 20, "after restart");
        finish_run();
    end

endmodule